// File: doc/BRIEF.md
# Random Replacement Slot Picker

This block chooses a victim entry for a translation buffer that replaces entries at random. The lowest entries of the buffer are locked and must never be replaced, so the pick always falls between the locked count and the entry count minus one. A 32-bit linear congruential generator supplies the randomness. Its upper half is folded into the legal band by an iterative remainder unit. A pick that matches the previously returned entry is thrown away and drawn again, so the same slot is never handed out twice in a row.

The requester raises `req_i` for a cycle with the entry count and locked count on the inputs. The block answers with a one-cycle `valid_o` pulse carrying `idx_o`. The answer comes at once when only one candidate exists or the inputs leave no free band. Otherwise it comes after one or more remainder passes.

Top module: `rnd_slot_pick`

## Requirements
- R1: After reset `valid_o` and `idx_o` are 0, the generator state is 1 and the remembered previous index is 0.
- R2: Every draw attempt replaces the generator state s with (s × 1103515245 + 12345) mod 2^32 before the candidate is formed.
- R3: A drawn candidate equals ((new state >> 16) mod (total − locked)) + locked, so it always lies in [locked, total − 1].
- R4: A candidate equal to the previously returned index is discarded and a new draw attempt follows, until the two differ.
- R5: When total − locked = 1, the block returns total − 1 with `valid_o` high right after the accepting clock edge, and the generator state is left unchanged.
- R6: When locked ≥ total, the block returns total − 1 in the same way as R5, again without advancing the generator state.
- R7: Every returned index, from either the draw path or the immediate path, becomes the previous index used by R4.
- R8: `valid_o` is high for exactly one cycle per accepted request. A `req_i` seen while a draw is in progress is ignored and changes neither the result nor the number of results.
- R9: Each draw attempt takes 17 clock cycles, so a drawn result appears 17 × n edges after the accepting edge, where n is the number of attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a new pick; accepted only when idle |
| total_i | input | 7 | Number of buffer entries, 1 to 64 |
| wired_i | input | 7 | Number of locked low entries |
| valid_o | output | 1 | One-cycle pulse: `idx_o` holds a fresh pick |
| idx_o | output | 6 | Chosen entry index |

## Verification
The bench builds the block with its default of 64 entries. This lets it request bands from the full 0..63 range down to two-entry bands at the top edge, where the R4 retry fires on roughly half the attempts and latencies of several attempts occur. It also reaches both immediate-return cases (single candidate and locked ≥ total) at the band extremes, including entry counts of 1 and 64. A reference generator in the bench predicts every index and the exact latency in attempts.

// File: rtl/rnd_slot_pick_pkg.sv
package rnd_slot_pick_pkg;

  localparam int unsigned SEED_W = 32;
  localparam int unsigned DRAW_W = SEED_W / 2;
  localparam logic [SEED_W-1:0] LCG_MUL   = 32'd1103515245;
  localparam logic [SEED_W-1:0] LCG_INC   = 32'd12345;
  localparam logic [SEED_W-1:0] SEED_INIT = 32'd1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } pick_state_e;

  // One generator step, wraps modulo 2^SEED_W
  function automatic logic [SEED_W-1:0] lcg_next(input logic [SEED_W-1:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

endpackage

// File: rtl/rnd_seed_reg.sv
module rnd_seed_reg
  import rnd_slot_pick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [DRAW_W-1:0] draw_o
);

  logic [SEED_W-1:0] seed_q;
  logic [SEED_W-1:0] seed_nxt;

  assign seed_nxt = lcg_next(seed_q);
  assign seed_o   = seed_q;
  // upper half of the state that the step is about to produce
  assign draw_o   = seed_nxt[SEED_W-1 -: DRAW_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= SEED_INIT;
    end else if (advance_i) begin
      seed_q <= seed_nxt;
    end
  end

endmodule

// File: rtl/rnd_mod_unit.sv
module rnd_mod_unit #(
  parameter int unsigned DVD_W = 16,
  parameter int unsigned DVS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVS_W-1:0] rem_o
);

  localparam int unsigned STEP_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  dvd_q;
  logic [DVS_W-1:0]  dvs_q;
  logic [DVS_W-1:0]  rem_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic              done_q;

  // restoring step: shift one dividend bit in, subtract when it fits
  function automatic logic [DVS_W-1:0] mod_step(input logic [DVS_W-1:0] r,
                                                input logic             b,
                                                input logic [DVS_W-1:0] d);
    logic [DVS_W:0] t;
    t = {r, b};
    if (t >= {1'b0, d}) t = t - {1'b0, d};
    return DVS_W'(t);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      dvd_q  <= dividend_i;
      dvs_q  <= divisor_i;
      rem_q  <= '0;
      step_q <= STEP_W'(DVD_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= mod_step(rem_q, dvd_q[DVD_W-1], dvs_q);
      dvd_q  <= dvd_q << 1;
      step_q <= step_q - STEP_W'(1);
      busy_q <= (step_q != STEP_W'(1));
      done_q <= (step_q == STEP_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;

endmodule

// File: rtl/rnd_slot_pick.sv
module rnd_slot_pick
  import rnd_slot_pick_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 64,
  localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int unsigned IDX_W = $clog2(MAX_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] wired_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  pick_state_e       state_q;
  logic [CNT_W-1:0]  wired_q;
  logic [CNT_W-1:0]  span_q;
  logic [IDX_W-1:0]  prev_q;
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;

  // named internal events, also observed by the bound checker
  logic              accept_w;
  logic              short_w;
  logic              short_evt_w;
  logic              first_draw_w;
  logic              div_done_w;
  logic              retry_w;
  logic              emit_draw_w;
  logic              advance_w;
  logic [CNT_W-1:0]  span_w;
  logic [CNT_W-1:0]  rem_w;
  logic [CNT_W-1:0]  cand_w;
  logic [SEED_W-1:0] seed_w;
  logic [DRAW_W-1:0] draw_w;

  assign span_w       = total_i - wired_i;
  assign short_w      = (wired_i >= total_i) || (span_w == CNT_W'(1));
  assign accept_w     = (state_q == ST_IDLE) && req_i;
  assign short_evt_w  = accept_w && short_w;
  assign first_draw_w = accept_w && !short_w;
  assign cand_w       = rem_w + wired_q;
  assign retry_w      = (state_q == ST_WAIT) && div_done_w && (cand_w == {1'b0, prev_q});
  assign emit_draw_w  = (state_q == ST_WAIT) && div_done_w && (cand_w != {1'b0, prev_q});
  assign advance_w    = first_draw_w || retry_w;

  rnd_seed_reg u_seed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (advance_w),
    .seed_o    (seed_w),
    .draw_o    (draw_w)
  );

  rnd_mod_unit #(
    .DVD_W (DRAW_W),
    .DVS_W (CNT_W)
  ) u_mod (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (advance_w),
    .dividend_i (draw_w),
    .divisor_i  (first_draw_w ? span_w : span_q),
    .done_o     (div_done_w),
    .rem_o      (rem_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wired_q <= '0;
      span_q  <= '0;
      prev_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (short_evt_w) begin
        idx_q   <= IDX_W'(total_i - CNT_W'(1));
        prev_q  <= IDX_W'(total_i - CNT_W'(1));
        valid_q <= 1'b1;
      end else if (first_draw_w) begin
        wired_q <= wired_i;
        span_q  <= span_w;
        state_q <= ST_WAIT;
      end else if (emit_draw_w) begin
        idx_q   <= IDX_W'(cand_w);
        prev_q  <= IDX_W'(cand_w);
        valid_q <= 1'b1;
        state_q <= ST_IDLE;
      end
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/rnd_slot_pick_chk.sv
module rnd_slot_pick_chk
  import rnd_slot_pick_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 64,
  localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int unsigned IDX_W = $clog2(MAX_ENTRIES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  total_i,
  input logic [CNT_W-1:0]  wired_i,
  input logic              valid_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              accept_w,
  input logic              short_w,
  input logic              short_evt_w,
  input logic              advance_w,
  input logic              div_done_w,
  input logic [SEED_W-1:0] seed_w
);

  logic [CNT_W-1:0] c_total;
  logic [CNT_W-1:0] c_wired;
  logic             c_short;
  logic [IDX_W-1:0] c_last;
  logic [7:0]       att_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_total <= '0;
      c_wired <= '0;
      c_short <= 1'b1;
      c_last  <= '0;
      att_cnt <= '0;
    end else begin
      if (accept_w) begin
        c_total <= total_i;
        c_wired <= wired_i;
        c_short <= short_w;
      end
      if (valid_o) c_last <= idx_o;
      if (advance_w) att_cnt <= '0;
      else if (att_cnt != 8'hFF) att_cnt <= att_cnt + 8'd1;
    end
  end

  AST_SEED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_w |=> seed_w == lcg_next($past(seed_w)));  // R2

  AST_IN_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !c_short) |-> ({1'b0, idx_o} >= c_wired) && ({1'b0, idx_o} < c_total));  // R3

  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !c_short) |-> idx_o != c_last);  // R4

  AST_SHORT_LAST_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_evt_w |=> valid_o && ({1'b0, idx_o} == $past(total_i) - CNT_W'(1)));  // R5

  AST_SHORT_SEED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_evt_w |=> $stable(seed_w));  // R6

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R8

  AST_ATTEMPT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done_w |-> att_cnt == 8'(DRAW_W));  // R9

endmodule

bind rnd_slot_pick rnd_slot_pick_chk #(.MAX_ENTRIES(MAX_ENTRIES)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .total_i     (total_i),
  .wired_i     (wired_i),
  .valid_o     (valid_o),
  .idx_o       (idx_o),
  .accept_w    (accept_w),
  .short_w     (short_w),
  .short_evt_w (short_evt_w),
  .advance_w   (advance_w),
  .div_done_w  (div_done_w),
  .seed_w      (seed_w)
);

// File: tb/rnd_slot_pick_tb_top.sv
`timescale 1ns/1ps
module rnd_slot_pick_tb_top;

  localparam int MAX_ENTRIES = 64;
  localparam int CW = 7;
  localparam int IW = 6;
  localparam int ATT_LAT = 17;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [CW-1:0] total = '0;
  logic [CW-1:0] wired = '0;
  logic          valid;
  logic [IW-1:0] idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int    q_idx[$];
  int    q_lat[$];
  int    q_stamp[$];
  string q_tag[$];

  logic [31:0] m_seed = 32'd1;
  int          m_prev = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rnd_slot_pick #(.MAX_ENTRIES(MAX_ENTRIES)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .total_i (total),
    .wired_i (wired),
    .valid_o (valid),
    .idx_o   (idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: predicts the pick and its latency, then issues the request
  task automatic issue(input int tot, input int wir, input bit pester, input string tag);
    int exp_idx;
    int n;
    n = 0;
    if (wir >= tot || tot - wir == 1) begin
      exp_idx = tot - 1;
    end else begin
      do begin
        m_seed = m_seed * 32'd1103515245 + 32'd12345;
        n++;
        exp_idx = int'(m_seed >> 16) % (tot - wir) + wir;
      end while (exp_idx == m_prev);
    end
    m_prev = exp_idx;
    @(negedge clk);
    q_idx.push_back(exp_idx);
    q_lat.push_back(n * ATT_LAT);
    q_stamp.push_back(cyc + 1);
    q_tag.push_back(tag);
    req = 1'b1;
    total = CW'(tot);
    wired = CW'(wir);
    @(negedge clk);
    if (pester) begin
      total = CW'(2);
      wired = CW'(0);
      repeat (3) @(negedge clk);
    end
    req = 1'b0;
    while (q_idx.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expectations as results appear
  initial begin
    bit last_v;
    last_v = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && valid) begin
        check(!last_v, "R8 pulse", 1, 0);
        if (q_idx.size() == 0) begin
          check(1'b0, "R8 unexpected result", int'(idx), -1);
        end else begin
          int e_idx;
          int e_lat;
          int e_st;
          string e_tag;
          e_idx = q_idx.pop_front();
          e_lat = q_lat.pop_front();
          e_st  = q_stamp.pop_front();
          e_tag = q_tag.pop_front();
          check(int'(idx) == e_idx, {e_tag, " index"}, int'(idx), e_idx);
          check(cyc - e_st == e_lat, {e_tag, " R9 latency"}, cyc - e_st, e_lat);
        end
      end
      last_v = valid;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    check(1'b0, "watchdog", cyc, WD_LIMIT);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    check(idx == '0, "R1 index after reset", int'(idx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(valid == 1'b0, "R1 idle valid", int'(valid), 0);

    for (int i = 0; i < 6; i++) issue(64, 0, 1'b0, "R1 R2 R3 full band");
    for (int i = 0; i < 6; i++) issue(16, 8, 1'b0, "R3 upper band");
    for (int i = 0; i < 10; i++) issue(2, 0, 1'b0, "R4 two-slot retry");
    issue(4, 3, 1'b0, "R5 single candidate");
    issue(4, 2, 1'b0, "R7 prev from short path");
    issue(5, 9, 1'b0, "R6 locked over total");
    issue(6, 4, 1'b0, "R7 prev from locked path");
    issue(32, 1, 1'b1, "R8 request while busy");
    issue(20, 5, 1'b1, "R8 request while busy again");
    issue(64, 63, 1'b0, "R5 top slot");
    issue(1, 0, 1'b0, "R5 one entry");
    for (int i = 0; i < 6; i++) issue(64, 62, 1'b0, "R4 top pair");
    for (int i = 0; i < 4; i++) issue(37, 11, 1'b0, "R3 odd band");

    repeat (40) @(negedge clk);
    check(q_idx.size() == 0, "R8 pending results", q_idx.size(), 0);
    check(valid == 1'b0, "R8 quiet after run", int'(valid), 0);
    finish_run();
  end

endmodule